// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block holds a set of independent timer channels. Each channel counts down from a programmed 64-bit interval and signals when the count runs out. A channel runs in one of two modes. In periodic mode it loads the interval again and keeps counting. In one-shot mode it halts at zero. Each channel has its own prescaler, which sets the rate of the decrements to a power-of-two fraction of the clock. All channels share one expiry flag register and one enable register. A single interrupt line is raised when any flagged channel is also enabled.

Software reaches the block through a plain 32-bit read/write register port. Read data is combinational in the cycle of the read strobe, and writes take effect at the clock edge. Each channel is driven by a small state machine with three states:

- `CH_IDLE`: frozen.
- `CH_RUN`: counting.
- `CH_DRAIN`: enable has been cleared, but counting goes on for a fixed number of clocks.

The transitions are:

- IDLE→RUN on a control write with enable set.
- RUN→DRAIN on a control write with enable clear.
- RUN→IDLE when a one-shot count expires.
- DRAIN→RUN on a control write with enable set.
- DRAIN→IDLE when the drain window ends, or when a one-shot count expires.

Top module: `evtimer_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The enable register is at 0x00 and the flag register at 0x04; bit n of each belongs to channel n, and bits at or above NUM_CH read 0. Channel n has a base address of 0x10 + 0x20·n. Its words sit at these offsets from the base: control +0x0, interval low +0x4, interval high +0x8, count low +0xC, count high +0x10. Both interval words read back as written.
- R3: In the control word, bit 0 is enable, bit 1 is reload, bits 6:4 are the prescaler select and bit 7 selects one-shot (1) or periodic (0). Reload always reads 0, and bits 3:2 read 0. A control write with enable clear loads nothing.
- R4: A control write with enable=1 and reload=1 copies the interval into the count. The count then drops by 1 on every 2^sel-th clock after that write.
- R5: In periodic mode the channel's flag is set by the clock edge that comes (interval+1)·2^sel edges after the start edge. The count then reloads the interval and runs on, so the next expiry comes a further (interval+1)·2^sel edges later.
- R6: In one-shot mode the channel stops at zero: the count stays 0, and the control enable bit reads 0 while the mode bit is kept.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An expiry sets the flag even when it is already set, and it wins over a clear at the same edge.
- R8: `irq` is high exactly when some channel has both its flag bit and its enable bit set.
- R9: After a control write with enable clear, the count goes on changing for DIS_LAT more clock edges and then freezes. The control enable bit reads 0 at once.
- R10: A read of count-low saves the count's high word. The next read of count-high returns that saved word, even if the counter has borrowed into the high word in between.
- R11: A control write with enable=1 and reload=0 on a stopped channel resumes counting from the held count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with two channels, a 64-bit counter and a drain window of three clocks. This makes the address decode of a second channel testable, along with a drain length that differs from the default. With intervals of 0 to 5 and prescaler selects of 0 to 2, the expiry edge of every combination is predicted and checked. This covers the single-tick interval, where an expiry and a flag clear meet on the same edge. A 64-bit interval of 0x1_0000_0002 forces a borrow out of the low word within a few cycles, which exercises the saved high word on reads.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    localparam int SEL_W       = 3;
    localparam int CTL_EN      = 0;
    localparam int CTL_RL      = 1;
    localparam int CTL_SEL_LSB = 4;
    localparam int CTL_OS      = 7;

    localparam int REG_IE      = 'h00;
    localparam int REG_ST      = 'h04;
    localparam int CH_BASE     = 'h10;
    localparam int CH_STRIDE   = 'h20;
    localparam int OFF_CTL     = 'h0;
    localparam int OFF_ILO     = 'h4;
    localparam int OFF_IHI     = 'h8;
    localparam int OFF_CLO     = 'hC;
    localparam int OFF_CHI     = 'h10;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_RUN,
        CH_DRAIN
    } ch_state_e;
endpackage

// File: rtl/evtimer_presc.sv
module evtimer_presc #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] mask;

    always_comb begin
        mask = ~(~PW'(0) << sel);
        tick = run && ((pcnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pcnt <= '0;
        else if (clr)     pcnt <= '0;
        else if (run)     pcnt <= pcnt + PW'(1);
    end
endmodule

// File: rtl/evtimer_chan.sv
module evtimer_chan
    import evtimer_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int DIS_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        ilo_wr,
    input  logic        ihi_wr,
    input  logic [31:0] wdata,
    output logic [63:0] ival_o,
    output logic [63:0] cnt_o,
    output logic [31:0] ctl_o,
    output logic        expire
);
    localparam int DC_W = $clog2(DIS_LAT + 1);

    ch_state_e          state, state_nx;
    logic [CNT_W-1:0]   cnt, ival;
    logic [63:0]        ival64;
    logic               en_q, os_q;
    logic [SEL_W-1:0]   sel_q;
    logic [DC_W-1:0]    dcnt;
    logic               start, ld, running, pclr, tick, term;

    assign start   = ctl_wr && wdata[CTL_EN];
    assign ld      = start && wdata[CTL_RL];
    assign running = (state != CH_IDLE);
    assign pclr    = ld || (start && state == CH_IDLE);
    assign term    = running && tick && (cnt == '0);
    assign ival64  = 64'(ival);

    evtimer_presc #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pclr),
        .run   (running),
        .sel   (sel_q),
        .tick  (tick)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:  if (start) state_nx = CH_RUN;
            CH_RUN: begin
                if (ctl_wr)              state_nx = start ? CH_RUN : CH_DRAIN;
                else if (term && os_q)   state_nx = CH_IDLE;
            end
            CH_DRAIN: begin
                if (start)                   state_nx = CH_RUN;
                else if (term && os_q)       state_nx = CH_IDLE;
                else if (dcnt == DC_W'(1))   state_nx = CH_IDLE;
            end
            default:  state_nx = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // datapath and visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            ival  <= '0;
            en_q  <= 1'b0;
            os_q  <= 1'b0;
            sel_q <= '0;
            dcnt  <= '0;
        end else begin
            if (ilo_wr) ival <= CNT_W'({ival64[63:32], wdata});
            if (ihi_wr) ival <= CNT_W'({wdata, ival64[31:0]});

            if (ctl_wr) begin
                en_q  <= wdata[CTL_EN];
                os_q  <= wdata[CTL_OS];
                sel_q <= wdata[CTL_SEL_LSB +: SEL_W];
            end else if (term && os_q) begin
                en_q  <= 1'b0;
            end

            if (ld)                       cnt <= ival;
            else if (term)                begin if (!os_q) cnt <= ival; end
            else if (running && tick)     cnt <= cnt - CNT_W'(1);

            if (state != CH_DRAIN && state_nx == CH_DRAIN) dcnt <= DC_W'(DIS_LAT);
            else if (state == CH_DRAIN)                    dcnt <= dcnt - DC_W'(1);
        end
    end

    assign expire = term;
    assign ival_o = 64'(ival);
    assign cnt_o  = 64'(cnt);
    assign ctl_o  = 32'({os_q, sel_q, 3'b000, en_q});

    AST_LOAD_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ival)));                                          // R4
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !os_q && !ld && !ilo_wr && !ihi_wr) |=> (cnt == $past(ival))); // R5
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (term && os_q && !ctl_wr) |=> (state == CH_IDLE && !en_q && cnt == '0)); // R6
    AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DRAIN) |-> (dcnt != '0 && dcnt <= DC_W'(DIS_LAT)));       // R9
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && !ctl_wr) |=> $stable(cnt));                       // R11
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int CNT_W   = 64,
    parameter int DIS_LAT = 2,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    logic [NUM_CH-1:0] ie_q, st_q, expire;
    logic [63:0]       ival [NUM_CH];
    logic [63:0]       cnt  [NUM_CH];
    logic [31:0]       ctl  [NUM_CH];
    logic [31:0]       shadow [NUM_CH];
    logic              hit_ie, hit_st;

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
        return ADDR_W'(CH_BASE + CH_STRIDE * ch + off);
    endfunction

    assign hit_ie = (addr == ADDR_W'(REG_IE));
    assign hit_st = (addr == ADDR_W'(REG_ST));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        evtimer_chan #(.CNT_W(CNT_W), .DIS_LAT(DIS_LAT)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_wr (wr_en && addr == ch_addr(g, OFF_CTL)),
            .ilo_wr (wr_en && addr == ch_addr(g, OFF_ILO)),
            .ihi_wr (wr_en && addr == ch_addr(g, OFF_IHI)),
            .wdata  (wdata),
            .ival_o (ival[g]),
            .cnt_o  (cnt[g]),
            .ctl_o  (ctl[g]),
            .expire (expire[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      shadow[g] <= '0;
            else if (rd_en && addr == ch_addr(g, OFF_CLO))   shadow[g] <= cnt[g][63:32];
        end

        AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> st_q[g]);                                            // R7
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] && !(wr_en && hit_st && wdata[g])) |=> st_q[g]);          // R7
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_en && hit_ie) ie_q <= wdata[NUM_CH-1:0];
            st_q <= (st_q & ~((wr_en && hit_st) ? wdata[NUM_CH-1:0] : '0)) | expire;
        end
    end

    assign irq = |(st_q & ie_q);

    always_comb begin
        rdata = '0;
        if (hit_ie) rdata = 32'(ie_q);
        if (hit_st) rdata = 32'(st_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ch_addr(i, OFF_CTL)) rdata = ctl[i];
            if (addr == ch_addr(i, OFF_ILO)) rdata = ival[i][31:0];
            if (addr == ch_addr(i, OFF_IHI)) rdata = ival[i][63:32];
            if (addr == ch_addr(i, OFF_CLO)) rdata = cnt[i][31:0];
            if (addr == ch_addr(i, OFF_CHI)) rdata = shadow[i];
        end
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);                                                // R8
endmodule

// File: tb/evtimer_top_test.sv
module evtimer_top_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    evtimer_top #(.NUM_CH(2), .CNT_W(64), .DIS_LAT(LAT), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] ca(input int ch, input int off);
        return 8'(32'h10 + 32'h20 * ch + off);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic stop_ch(input int ch);
        wr(ca(ch, 0), 32'h0);
        repeat (LAT + 2) @(negedge clk);
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq && k < 2000);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, d);      chk("R1 ie", d, 0);
        rd(8'h04, d);      chk("R1 st", d, 0);
        rd(ca(0, 0), d);   chk("R1 ctl", d, 0);
        rd(ca(1, 'hC), d); chk("R1 cnt", d, 0);
        chk("R1 irq", irq, 0);

        // R2 address map
        wr(ca(0, 4), 32'h1111_2222); wr(ca(0, 8), 32'h3333_4444);
        wr(ca(1, 4), 32'h5555_6666); wr(ca(1, 8), 32'h7777_8888);
        rd(ca(0, 4), d); chk("R2 ilo0", d, 32'h1111_2222);
        rd(ca(0, 8), d); chk("R2 ihi0", d, 32'h3333_4444);
        rd(ca(1, 4), d); chk("R2 ilo1", d, 32'h5555_6666);
        rd(ca(1, 8), d); chk("R2 ihi1", d, 32'h7777_8888);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R2 ie width", d, 32'h3);
        wr(8'h00, 32'h0);

        // R3 control fields, reload without enable
        wr(ca(0, 0), 32'hF6);
        rd(ca(0, 0), d);   chk("R3 ctl readback", d, 32'hF0);
        rd(ca(0, 'hC), d); chk("R3 no load", d, 0);
        wr(ca(0, 0), 32'h0);

        // R5 / R7 sweep of interval and prescaler
        wr(8'h00, 32'h1);
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 6; v++) begin
                stop_ch(0);
                wr(ca(0, 4), 32'(v));
                wr(ca(0, 8), 32'h0);
                n = (v + 1) << s;
                wr(ca(0, 0), 32'h3 | 32'(s << 4));
                wait_irq(k);
                chk("R5 first expiry", k, n);
                wr(8'h04, 32'h1);
                if (n == 1) begin
                    chk("R7 set beats clear", irq, 1);
                end else begin
                    chk("R7 clear", irq, 0);
                    k = n + 1;
                    while (!irq && k < 2000) begin
                        @(negedge clk);
                        k++;
                    end
                    chk("R5 periodic repeat", k, 2 * n);
                end
            end
        end
        stop_ch(0);

        // R4 decrement rate with sel=2
        wr(ca(0, 4), 32'd100);
        wr(ca(0, 0), 32'h23);
        repeat (13) @(negedge clk);
        rd(ca(0, 'hC), d); chk("R4 count k13", d, 32'd97);
        repeat (6) @(negedge clk);
        rd(ca(0, 'hC), d); chk("R4 count k20", d, 32'd95);
        stop_ch(0);

        // R9 drain after disable, R11 resume
        wr(ca(0, 4), 32'd1000);
        wr(ca(0, 0), 32'h3);
        repeat (10) @(negedge clk);
        wr(ca(0, 0), 32'h0);
        rd(ca(0, 0), d);   chk("R9 enable reads 0", d, 0);
        repeat (10) @(negedge clk);
        rd(ca(0, 'hC), d); chk("R9 drained count", d, 32'd986);
        rd(ca(0, 'hC), d); chk("R9 frozen", d, 32'd986);
        wr(ca(0, 0), 32'h1);
        repeat (4) @(negedge clk);
        rd(ca(0, 'hC), d); chk("R11 resume", d, 32'd982);
        stop_ch(0);

        // R6 one-shot
        wr(ca(0, 4), 32'd3);
        wr(ca(0, 0), 32'h83);
        wait_irq(k);
        chk("R6 expiry", k, 4);
        repeat (5) @(negedge clk);
        rd(ca(0, 0), d);   chk("R6 ctl after", d, 32'h80);
        rd(ca(0, 'hC), d); chk("R6 count held", d, 0);
        wr(8'h04, 32'h1);
        repeat (10) @(negedge clk);
        chk("R6 no re-fire", irq, 0);

        // R10 coherent 64-bit read
        wr(ca(1, 4), 32'd2);
        wr(ca(1, 8), 32'd1);
        wr(ca(1, 0), 32'h3);
        rd(ca(1, 'hC), d); chk("R10 lo k0", d, 32'd2);
        repeat (5) @(negedge clk);
        rd(ca(1, 'h10), d); chk("R10 saved hi", d, 32'd1);
        rd(ca(1, 'hC), d);  chk("R10 lo k7", d, 32'hFFFF_FFFB);
        rd(ca(1, 'h10), d); chk("R10 new hi", d, 32'd0);
        stop_ch(1);

        // R8 interrupt gating
        wr(8'h00, 32'h0);
        wr(ca(1, 4), 32'd2);
        wr(ca(1, 8), 32'd0);
        wr(ca(1, 0), 32'h3);
        repeat (10) @(negedge clk);
        rd(8'h04, d); chk("R8 flag set", d & 32'h2, 32'h2);
        chk("R8 masked", irq, 0);
        wr(8'h00, 32'h2);
        chk("R8 enabled", irq, 1);
        wr(8'h00, 32'h1);
        chk("R8 other enable", irq, 0);
        stop_ch(1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule